// File: doc/BRIEF.md
# Unified Address Translation Buffer with Lookup-Driven Replacement Counter

This block is the shared translation table of a processor memory unit. It keeps 64 fully associative entries. Each entry holds a virtual page tag, an 8-bit address-space identifier, a physical page, nine attribute bits and a 4-bit extra attribute field. Entries may cover 1 KB, 4 KB, 64 KB or 1 MB pages. A lookup presents a virtual address, an address-space identifier and a flag that tells the table to ignore that identifier. One cycle later the table reports a single hit with its slot index, a miss, or a multi-hit.

Software fills the table in two ways. A load command copies three staged words (high, low and extra-attribute words) into the slot named by a replacement counter. That counter steps on every lookup and wraps at a boundary that software sets. A memory-mapped array port gives direct writes and reads of the address and data halves of any slot. It also gives an associative write, which searches the table and changes only the valid and dirty bits of the one entry it finds. A global invalidate drops every valid bit in one cycle.

Top module: `xlat_utlb`

## Requirements
- R1: After reset every entry is invalid, the replacement counter reads 0, and no lookup response, read response or associative multi-hit pulse is shown.
- R2: An entry matches when its valid bit (attribute bit 8) is set, its address-space identifier matches or is exempt, and the virtual address agrees with its tag on all bits the page size keeps. A lookup is answered on the cycle after the request: `lk_valid_o` high, and either `lk_hit_o` with `lk_idx_o` naming the single matching slot, or neither flag for a miss.
- R3: The page size comes from attribute bits {7,4}: 00 = 1 KB (tag bits 31:10 compared), 01 = 4 KB (31:12), 10 = 64 KB (31:16), 11 = 1 MB (31:20).
- R4: The identifier compare is skipped when the entry's share bit (attribute bit 1) is set or when `lk_ign_asid_i` is high.
- R5: Two or more matching entries give `lk_multi_o` high, with `lk_hit_o` low and `lk_idx_o` 0.
- R6: The replacement counter increments on every lookup request. When the incremented value equals `wrap_bound_i` or equals 64 it becomes 0 instead. Without a lookup it holds.
- R7: `load_i` writes the slot given by the counter: tag from `stage_hi_i[31:10]`, identifier from `stage_hi_i[7:0]`, physical page from `stage_lo_i[28:10]`, attributes from `stage_lo_i[8:0]`, and extra field from `stage_attr_i`. The counter is not changed by the load.
- R8: Array accesses select the slot with address bits 13:8. A direct address-array write (`arr_data_sel_i` low, address bit 7 low) sets the tag from data bits 31:10 and the identifier from 7:0, sets valid from data bit 8 and dirty (attribute bit 2) from data bit 9, and leaves all other attributes as they were. An address-array read returns {tag, dirty at bit 9, valid at bit 8, identifier in 7:0}.
- R9: With `arr_data_sel_i` high, address bit 23 low selects the physical page and attributes: a write takes data bits 28:10 and 8:0, and a read returns {000, page in 28:10, 0 at bit 9, attributes in 8:0}. Address bit 23 high selects the extra field in data bits 3:0, and a read returns it zero-extended.
- R10: An associative write (address array, address bit 7 high) searches with tag `arr_wdata_i[31:10]`, identifier `cur_asid_i` and the R2 to R4 rules, with no identifier exemption beyond the share bit. On exactly one match it sets that entry's valid from data bit 9's neighbour bit 8 and dirty from bit 9. Tag, identifier and other attributes are kept. With no match nothing changes.
- R11: An associative write that matches two or more entries changes nothing and raises `arr_multi_o` for one cycle on the next cycle.
- R12: `inval_i` clears the valid bit of every entry on the next edge and leaves tags, pages, dirty and other attributes unchanged.
- R13: At most one of `load_i`, `arr_wr_i` and `inval_i` is high in a cycle. A lookup or array read in the same cycle as any of them sees the table as it stood before that edge. Array read data appears with `arr_rvalid_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_asid_i | input | 8 | Lookup address-space identifier |
| lk_ign_asid_i | input | 1 | Skip the identifier compare for this lookup |
| lk_valid_o | output | 1 | Lookup response present |
| lk_hit_o | output | 1 | Single matching entry |
| lk_multi_o | output | 1 | Two or more matching entries |
| lk_idx_o | output | 6 | Slot index of the single hit |
| wrap_bound_i | input | 6 | Counter wrap boundary |
| repl_ctr_o | output | 6 | Replacement counter value |
| cur_asid_i | input | 8 | Current identifier used by associative writes |
| stage_hi_i | input | 32 | Staged tag and identifier word |
| stage_lo_i | input | 32 | Staged page and attribute word |
| stage_attr_i | input | 4 | Staged extra attribute field |
| load_i | input | 1 | Load staged words into the counter's slot |
| arr_wr_i | input | 1 | Array write strobe |
| arr_rd_i | input | 1 | Array read strobe |
| arr_data_sel_i | input | 1 | 0 = address array, 1 = data array |
| arr_addr_i | input | 32 | Array access address |
| arr_wdata_i | input | 32 | Array write data |
| arr_rvalid_o | output | 1 | Array read data present |
| arr_rdata_o | output | 32 | Array read data |
| arr_multi_o | output | 1 | Associative write matched several entries |
| inval_i | input | 1 | Global invalidate |

## Verification
A wrong valid, size, share or identifier bit in any slot appears as a wrong hit, miss, multi-hit or index on the response one cycle after the first lookup that touches that page. A corrupted field also appears on the next array read of that slot. The replacement counter is visible on its own port, so a wrong step or a wrong wrap shows on the cycle after the offending lookup. A load into the wrong slot shows when that slot is read back. Every cycle is compared against a behavioural model of the table, so a divergence is reported within one clock of the first visible effect.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W      = 32;
  localparam int PG_LSB    = 10;
  localparam int VPN_W     = VA_W - PG_LSB;
  localparam int PA_TOP    = 29;
  localparam int PPN_W     = PA_TOP - PG_LSB;
  localparam int ASID_W    = 8;
  localparam int FLAG_W    = 9;
  localparam int XATTR_W   = 4;

  // attribute bit positions
  localparam int F_VALID   = 8;
  localparam int F_SZ_HI   = 7;
  localparam int F_SZ_LO   = 4;
  localparam int F_DIRTY   = 2;
  localparam int F_SHARE   = 1;

  // array-port address / data decode
  localparam int SEL_LSB   = 8;
  localparam int ASSOC_BIT = 7;
  localparam int XSEL_BIT  = 23;
  localparam int DIRTY_IN  = 9;

  typedef enum logic [1:0] {
    PG_1K  = 2'b00,
    PG_4K  = 2'b01,
    PG_64K = 2'b10,
    PG_1M  = 2'b11
  } pg_size_e;

  // tag bits that take part in the compare for a page size
  function automatic logic [VPN_W-1:0] vpn_keep(input logic [1:0] sz);
    case (pg_size_e'(sz))
      PG_1K:   return '1;
      PG_4K:   return ~VPN_W'(3);
      PG_64K:  return ~VPN_W'(63);
      default: return ~VPN_W'(1023);
    endcase
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [VPN_W-1:0]  ent_vpn   [ENTRIES],
  input  logic [ASID_W-1:0] ent_asid  [ENTRIES],
  input  logic [FLAG_W-1:0] ent_flags [ENTRIES],
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic              q_ign,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [VPN_W-1:0] keep;
    logic             asid_ok;
    logic             tag_ok;
    logic             unused_fl;

    assign keep      = vpn_keep({ent_flags[e][F_SZ_HI], ent_flags[e][F_SZ_LO]});
    assign asid_ok   = ent_flags[e][F_SHARE] | q_ign | (ent_asid[e] == q_asid);
    assign tag_ok    = ((ent_vpn[e] ^ q_vpn) & keep) == '0;
    assign hit_vec[e] = ent_flags[e][F_VALID] & asid_ok & tag_ok;
    assign unused_fl = ^{ent_flags[e][0], ent_flags[e][2], ent_flags[e][3],
                         ent_flags[e][5], ent_flags[e][6]};
  end
endmodule

// File: rtl/xlat_hitenc.sv
module xlat_hitenc #(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               single_o,
  output logic               multi_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic             seen;
  logic             second;
  logic [IDX_W-1:0] idx_acc;

  always_comb begin
    seen    = 1'b0;
    second  = 1'b0;
    idx_acc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        second  = second | seen;
        seen    = 1'b1;
        idx_acc = idx_acc | IDX_W'(i);
      end
    end
    single_o = seen & ~second;
    multi_o  = second;
    idx_o    = (seen & ~second) ? idx_acc : '0;
  end
endmodule

// File: rtl/xlat_repl_ctr.sv
module xlat_repl_ctr #(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] bound_i,
  output logic [IDX_W-1:0] ctr_o
);
  logic [IDX_W-1:0] ctr_q;
  logic [IDX_W-1:0] ctr_d;
  logic [IDX_W:0]   inc;

  always_comb begin
    inc   = {1'b0, ctr_q} + 1'b1;
    ctr_d = ctr_q;
    if (adv_i) begin
      if (inc == (IDX_W+1)'(ENTRIES) || inc == {1'b0, bound_i}) ctr_d = '0;
      else                                                       ctr_d = inc[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctr_q <= '0;
    else if (adv_i)  ctr_q <= ctr_d;
  end

  assign ctr_o = ctr_q;

  // R6: each lookup moves the counter one step forward or back to zero
  assert_ctr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (ctr_o == '0) || (ctr_o == $past(ctr_o) + 1'b1));
  // R6 / R7: no lookup, no movement (a load alone leaves it alone)
  assert_ctr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(ctr_o));
endmodule

// File: rtl/xlat_utlb.sv
module xlat_utlb
  import xlat_pkg::*;
#(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req_i,
  input  logic [31:0]       lk_vaddr_i,
  input  logic [7:0]        lk_asid_i,
  input  logic              lk_ign_asid_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic              lk_multi_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  logic [IDX_W-1:0]  wrap_bound_i,
  output logic [IDX_W-1:0]  repl_ctr_o,
  input  logic [7:0]        cur_asid_i,
  input  logic [31:0]       stage_hi_i,
  input  logic [31:0]       stage_lo_i,
  input  logic [3:0]        stage_attr_i,
  input  logic              load_i,
  input  logic              arr_wr_i,
  input  logic              arr_rd_i,
  input  logic              arr_data_sel_i,
  input  logic [31:0]       arr_addr_i,
  input  logic [31:0]       arr_wdata_i,
  output logic              arr_rvalid_o,
  output logic [31:0]       arr_rdata_o,
  output logic              arr_multi_o,
  input  logic              inval_i
);
  // ---- table storage ----
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic [ASID_W-1:0]  asid_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [ENTRIES];
  logic [FLAG_W-1:0]  flags_q [ENTRIES];
  logic [XATTR_W-1:0] xattr_q [ENTRIES];

  logic [VPN_W-1:0]   vpn_d   [ENTRIES];
  logic [ASID_W-1:0]  asid_d  [ENTRIES];
  logic [PPN_W-1:0]   ppn_d   [ENTRIES];
  logic [FLAG_W-1:0]  flags_d [ENTRIES];
  logic [XATTR_W-1:0] xattr_d [ENTRIES];
  logic [ENTRIES-1:0] ent_we;

  logic [IDX_W-1:0]   ctr;
  logic [IDX_W-1:0]   sel;
  logic               wr_direct, wr_assoc, wr_data;

  assign sel       = arr_addr_i[SEL_LSB +: IDX_W];
  assign wr_direct = arr_wr_i & ~arr_data_sel_i & ~arr_addr_i[ASSOC_BIT];
  assign wr_assoc  = arr_wr_i & ~arr_data_sel_i &  arr_addr_i[ASSOC_BIT];
  assign wr_data   = arr_wr_i &  arr_data_sel_i;

  // ---- lookup search ----
  logic [ENTRIES-1:0] lk_vec;
  logic               lk_single, lk_many;
  logic [IDX_W-1:0]   lk_idx;

  xlat_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .ent_vpn(vpn_q), .ent_asid(asid_q), .ent_flags(flags_q),
    .q_vpn(lk_vaddr_i[VA_W-1:PG_LSB]), .q_asid(lk_asid_i), .q_ign(lk_ign_asid_i),
    .hit_vec(lk_vec));

  xlat_hitenc #(.ENTRIES(ENTRIES)) u_lk_enc (
    .hit_vec(lk_vec), .single_o(lk_single), .multi_o(lk_many), .idx_o(lk_idx));

  // ---- associative-write search ----
  logic [ENTRIES-1:0] as_vec;
  logic               as_single, as_many;
  logic [IDX_W-1:0]   as_idx;

  xlat_match #(.ENTRIES(ENTRIES)) u_as_match (
    .ent_vpn(vpn_q), .ent_asid(asid_q), .ent_flags(flags_q),
    .q_vpn(arr_wdata_i[VA_W-1:PG_LSB]), .q_asid(cur_asid_i), .q_ign(1'b0),
    .hit_vec(as_vec));

  xlat_hitenc #(.ENTRIES(ENTRIES)) u_as_enc (
    .hit_vec(as_vec), .single_o(as_single), .multi_o(as_many), .idx_o(as_idx));

  // ---- replacement counter ----
  xlat_repl_ctr #(.ENTRIES(ENTRIES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv_i(lk_req_i), .bound_i(wrap_bound_i), .ctr_o(ctr));

  assign repl_ctr_o = ctr;

  // ---- per-entry next state ----
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vpn_d[i]   = vpn_q[i];
      asid_d[i]  = asid_q[i];
      ppn_d[i]   = ppn_q[i];
      flags_d[i] = flags_q[i];
      xattr_d[i] = xattr_q[i];
      ent_we[i]  = 1'b0;
      if (load_i && ctr == IDX_W'(i)) begin
        ent_we[i]  = 1'b1;
        vpn_d[i]   = stage_hi_i[VA_W-1:PG_LSB];
        asid_d[i]  = stage_hi_i[ASID_W-1:0];
        ppn_d[i]   = stage_lo_i[PA_TOP-1:PG_LSB];
        flags_d[i] = stage_lo_i[FLAG_W-1:0];
        xattr_d[i] = stage_attr_i;
      end else if (wr_direct && sel == IDX_W'(i)) begin
        ent_we[i]           = 1'b1;
        vpn_d[i]            = arr_wdata_i[VA_W-1:PG_LSB];
        asid_d[i]           = arr_wdata_i[ASID_W-1:0];
        flags_d[i][F_VALID] = arr_wdata_i[F_VALID];
        flags_d[i][F_DIRTY] = arr_wdata_i[DIRTY_IN];
      end else if (wr_assoc && as_single && as_idx == IDX_W'(i)) begin
        ent_we[i]           = 1'b1;
        flags_d[i][F_VALID] = arr_wdata_i[F_VALID];
        flags_d[i][F_DIRTY] = arr_wdata_i[DIRTY_IN];
      end else if (wr_data && sel == IDX_W'(i)) begin
        ent_we[i] = 1'b1;
        if (arr_addr_i[XSEL_BIT]) begin
          xattr_d[i] = arr_wdata_i[XATTR_W-1:0];
        end else begin
          ppn_d[i]   = arr_wdata_i[PA_TOP-1:PG_LSB];
          flags_d[i] = arr_wdata_i[FLAG_W-1:0];
        end
      end else if (inval_i) begin
        ent_we[i]           = 1'b1;
        flags_d[i][F_VALID] = 1'b0;
      end
    end
  end

  // datapath fields carry no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_we[i]) begin
        vpn_q[i]   <= vpn_d[i];
        asid_q[i]  <= asid_d[i];
        ppn_q[i]   <= ppn_d[i];
        xattr_q[i] <= xattr_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) flags_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) if (ent_we[i]) flags_q[i] <= flags_d[i];
    end
  end

  // ---- response registers ----
  logic [31:0] rdata_d;

  always_comb begin
    if (!arr_data_sel_i)
      rdata_d = {vpn_q[sel], flags_q[sel][F_DIRTY], flags_q[sel][F_VALID], asid_q[sel]};
    else if (arr_addr_i[XSEL_BIT])
      rdata_d = {{(32-XATTR_W){1'b0}}, xattr_q[sel]};
    else
      rdata_d = {{(VA_W-PA_TOP){1'b0}}, ppn_q[sel], 1'b0, flags_q[sel]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_valid_o   <= 1'b0;
      lk_hit_o     <= 1'b0;
      lk_multi_o   <= 1'b0;
      lk_idx_o     <= '0;
      arr_rvalid_o <= 1'b0;
      arr_rdata_o  <= '0;
      arr_multi_o  <= 1'b0;
    end else begin
      lk_valid_o   <= lk_req_i;
      lk_hit_o     <= lk_req_i & lk_single;
      lk_multi_o   <= lk_req_i & lk_many;
      lk_idx_o     <= lk_req_i ? lk_idx : '0;
      arr_rvalid_o <= arr_rd_i;
      if (arr_rd_i) arr_rdata_o <= rdata_d;
      arr_multi_o  <= wr_assoc & as_many;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{lk_vaddr_i[PG_LSB-1:0], arr_addr_i, stage_hi_i[9:8],
                         stage_lo_i[VA_W-1:PA_TOP], stage_lo_i[9]};

  // ---- assertions ----
  logic [ENTRIES-1:0] valid_vec;
  always_comb for (int i = 0; i < ENTRIES; i++) valid_vec[i] = flags_q[i][F_VALID];

  // R13: table-changing commands never share a cycle
  assert_cmd_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_i, arr_wr_i, inval_i}));
  // R2: a response follows each request by exactly one cycle
  assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> lk_valid_o);
  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req_i |=> !lk_valid_o && !lk_hit_o && !lk_multi_o);
  // R5: hit and multi-hit are exclusive
  assert_hit_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit_o && lk_multi_o));
  // R12: after a global invalidate no entry is valid
  assert_inval_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inval_i |=> (valid_vec == '0));
  // R11: multi-hit pulse only after an array write
  assert_amulti_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_multi_o |-> $past(arr_wr_i));
endmodule

// File: tb/xlat_utlb_tb.sv
`timescale 1ns/100ps
module xlat_utlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_ign = 1'b0;
  logic        lk_valid, lk_hit, lk_multi;
  logic [5:0]  lk_idx;
  logic [5:0]  wrap_bound = '0;
  logic [5:0]  repl_ctr;
  logic [7:0]  cur_asid = '0;
  logic [31:0] stage_hi = '0, stage_lo = '0;
  logic [3:0]  stage_attr = '0;
  logic        load = 1'b0, arr_wr = 1'b0, arr_rd = 1'b0, arr_dsel = 1'b0, inval = 1'b0;
  logic [31:0] arr_addr = '0, arr_wdata = '0;
  logic        arr_rvalid, arr_multi;
  logic [31:0] arr_rdata;

  always #2.5 clk = ~clk;

  xlat_utlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_req_i(lk_req), .lk_vaddr_i(lk_vaddr), .lk_asid_i(lk_asid), .lk_ign_asid_i(lk_ign),
    .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_multi_o(lk_multi), .lk_idx_o(lk_idx),
    .wrap_bound_i(wrap_bound), .repl_ctr_o(repl_ctr), .cur_asid_i(cur_asid),
    .stage_hi_i(stage_hi), .stage_lo_i(stage_lo), .stage_attr_i(stage_attr), .load_i(load),
    .arr_wr_i(arr_wr), .arr_rd_i(arr_rd), .arr_data_sel_i(arr_dsel), .arr_addr_i(arr_addr),
    .arr_wdata_i(arr_wdata), .arr_rvalid_o(arr_rvalid), .arr_rdata_o(arr_rdata),
    .arr_multi_o(arr_multi), .inval_i(inval));

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;
  string phase = "R1 reset state";

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit [31:0] m_vpn   [64];
  bit [7:0]  m_asid  [64];
  bit [31:0] m_ppn   [64];
  bit [8:0]  m_flags [64];
  bit [3:0]  m_xattr [64];
  int        m_ctr;
  bit        e_lv, e_hit, e_multi, e_rv, e_am;
  int        e_idx;
  bit [31:0] e_rd;

  function automatic bit [31:0] page_mask(bit [8:0] f);
    case (f & 9'h090)
      9'h000:  return 32'hFFFF_FC00;
      9'h010:  return 32'hFFFF_F000;
      9'h080:  return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic bit m_match(int i, bit [31:0] va, bit [7:0] as, bit ign);
    return m_flags[i][8] && (m_flags[i][1] || ign || m_asid[i] == as) &&
           (((m_vpn[i] ^ va) & page_mask(m_flags[i])) == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_flags[i] = '0;
      m_ctr = 0; e_lv = 0; e_hit = 0; e_multi = 0; e_idx = 0; e_rv = 0; e_am = 0;
    end else begin
      int cnt, first, acnt, afirst, s;
      cnt = 0; first = 0; acnt = 0; afirst = 0;
      s = int'(arr_addr[13:8]);
      for (int i = 0; i < 64; i++) begin
        if (m_match(i, lk_vaddr, lk_asid, lk_ign)) begin cnt++; first = i; end
        if (m_match(i, arr_wdata, cur_asid, 1'b0)) begin acnt++; afirst = i; end
      end
      e_lv = lk_req; e_hit = lk_req && cnt == 1; e_multi = lk_req && cnt > 1;
      e_idx = (lk_req && cnt == 1) ? first : 0;
      e_rv = arr_rd;
      if (arr_rd) begin
        if (!arr_dsel)
          e_rd = m_vpn[s] | (32'(m_flags[s][2]) << 9) | (32'(m_flags[s][8]) << 8) | 32'(m_asid[s]);
        else if (arr_addr[23]) e_rd = 32'(m_xattr[s]);
        else                   e_rd = m_ppn[s] | 32'(m_flags[s]);
      end
      e_am = arr_wr && !arr_dsel && arr_addr[7] && acnt > 1;
      if (load) begin
        m_vpn[m_ctr] = stage_hi & 32'hFFFF_FC00; m_asid[m_ctr] = stage_hi[7:0];
        m_ppn[m_ctr] = stage_lo & 32'h1FFF_FC00; m_flags[m_ctr] = stage_lo[8:0];
        m_xattr[m_ctr] = stage_attr;
      end
      if (arr_wr && !arr_dsel && !arr_addr[7]) begin
        m_vpn[s] = arr_wdata & 32'hFFFF_FC00; m_asid[s] = arr_wdata[7:0];
        m_flags[s][8] = arr_wdata[8]; m_flags[s][2] = arr_wdata[9];
      end
      if (arr_wr && !arr_dsel && arr_addr[7] && acnt == 1) begin
        m_flags[afirst][8] = arr_wdata[8]; m_flags[afirst][2] = arr_wdata[9];
      end
      if (arr_wr && arr_dsel) begin
        if (arr_addr[23]) m_xattr[s] = arr_wdata[3:0];
        else begin m_ppn[s] = arr_wdata & 32'h1FFF_FC00; m_flags[s] = arr_wdata[8:0]; end
      end
      if (inval) for (int i = 0; i < 64; i++) m_flags[i][8] = 1'b0;
      if (lk_req) begin
        m_ctr = m_ctr + 1;
        if (m_ctr == int'(wrap_bound) || m_ctr == 64) m_ctr = 0;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 replacement counter", 32'(repl_ctr), 32'(m_ctr));
      check({phase, " lookup valid"}, 32'(lk_valid), 32'(e_lv));
      if (e_lv) begin
        check({phase, " hit"},   32'(lk_hit),   32'(e_hit));
        check({phase, " multi"}, 32'(lk_multi), 32'(e_multi));
        check({phase, " index"}, 32'(lk_idx),   32'(e_idx));
      end
      check("R13 read valid", 32'(arr_rvalid), 32'(e_rv));
      if (e_rv) check({phase, " read data"}, arr_rdata, e_rd);
      check("R11 associative multi-hit", 32'(arr_multi), 32'(e_am));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk); #1;
    lk_req = 0; load = 0; arr_wr = 0; arr_rd = 0; inval = 0;
  endtask
  task automatic do_lookup(logic [31:0] va, logic [7:0] as, logic ign);
    step(); lk_req = 1; lk_vaddr = va; lk_asid = as; lk_ign = ign;
  endtask
  task automatic do_awr(int idx, logic [31:0] d);
    step(); arr_wr = 1; arr_dsel = 0; arr_addr = 32'(idx) << 8; arr_wdata = d;
  endtask
  task automatic do_assoc(logic [31:0] d);
    step(); arr_wr = 1; arr_dsel = 0; arr_addr = 32'h80; arr_wdata = d;
  endtask
  task automatic do_dwr(int idx, bit xt, logic [31:0] d);
    step(); arr_wr = 1; arr_dsel = 1; arr_addr = (32'(idx) << 8) | (xt ? 32'h0080_0000 : 0); arr_wdata = d;
  endtask
  task automatic do_ard(int idx);
    step(); arr_rd = 1; arr_dsel = 0; arr_addr = 32'(idx) << 8;
  endtask
  task automatic do_drd(int idx, bit xt);
    step(); arr_rd = 1; arr_dsel = 1; arr_addr = (32'(idx) << 8) | (xt ? 32'h0080_0000 : 0);
  endtask
  task automatic do_load(logic [31:0] hi, logic [31:0] lo, logic [3:0] at, bit with_lk);
    step(); load = 1; stage_hi = hi; stage_lo = lo; stage_attr = at;
    if (with_lk) begin lk_req = 1; lk_vaddr = hi; lk_asid = hi[7:0]; lk_ign = 0; end
  endtask

  localparam logic [31:0] V = 32'h100, SZ4K = 32'h010, SZ1M = 32'h090, USR = 32'h040, SH = 32'h002;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 counter after reset", 32'(repl_ctr), 32'd0);
    check("R1 no lookup response after reset", 32'(lk_valid), 32'd0);
    check("R1 no read response after reset", 32'(arr_rvalid), 32'd0);
    do_lookup(32'h0040_0000, 8'h11, 0);

    phase = "R9 data array";
    do_dwr(3, 0, 32'h0C12_3400 | V | SZ4K | USR);
    do_dwr(3, 1, 32'hFFFF_FFFA);
    do_drd(3, 0); do_drd(3, 1);
    do_dwr(5, 0, 32'hE005_5400 | V);
    do_dwr(7, 0, 32'h1FF0_0000 | V | SZ1M | SH);
    do_dwr(9, 0, 32'h0020_0000 | V | SZ4K);
    do_drd(5, 0);

    phase = "R8 address array";
    do_awr(3, 32'h0040_0000 | 32'h200 | V | 32'h11);
    do_awr(5, 32'h0080_0000 | V | 32'h33);
    do_awr(7, 32'h0100_0000 | V | 32'h22);
    do_ard(3); do_ard(5); do_ard(7);

    phase = "R2 lookup";
    do_lookup(32'h0040_0123, 8'h11, 0);
    do_lookup(32'h0040_0123, 8'h12, 0);
    do_lookup(32'h0040_0000, 8'h11, 0);

    phase = "R3 page size";
    do_lookup(32'h0040_0C00, 8'h11, 0);
    do_lookup(32'h0040_1000, 8'h11, 0);
    do_lookup(32'h0080_0300, 8'h33, 0);
    do_lookup(32'h0080_0400, 8'h33, 0);
    do_lookup(32'h010A_BCDE, 8'h22, 0);
    do_lookup(32'h0110_0000, 8'h22, 0);

    phase = "R4 identifier exemption";
    do_lookup(32'h0040_0000, 8'h55, 1);
    do_lookup(32'h010A_BCDE, 8'h99, 0);

    phase = "R5 multi-hit";
    do_awr(9, 32'h0040_0000 | V | 32'h11);
    do_lookup(32'h0040_0000, 8'h11, 0);
    do_lookup(32'h0040_0800, 8'h12, 1);

    phase = "R11 associative multi-hit";
    cur_asid = 8'h11;
    do_assoc(32'h0040_0000);
    do_ard(3); do_ard(9);

    phase = "R10 associative write";
    do_awr(9, 32'h0040_0000 | 32'h11);
    do_assoc(32'h0040_0000 | V);
    do_ard(3);
    cur_asid = 8'h44;
    do_assoc(32'h0080_0000);
    do_ard(5);
    do_assoc(32'h0100_0000 | 32'h200);
    do_ard(7); do_drd(7, 0);
    do_lookup(32'h0100_0000, 8'h22, 0);

    phase = "R6 counter wrap at bound";
    wrap_bound = 6'd5;
    for (int k = 0; k < 70; k++) do_lookup(32'(k) << 12, 8'h11, 0);
    phase = "R6 counter wrap at 64";
    wrap_bound = 6'd0;
    for (int k = 0; k < 70; k++) do_lookup(32'h0080_0000, 8'h33, k[0]);

    phase = "R7 load entry";
    begin
      int slot;
      step();
      slot = m_ctr;
      do_load(32'h1234_5B77, 32'hE0C3_A552, 4'h5, 0);
      do_ard(slot); do_drd(slot, 0); do_drd(slot, 1);
      do_lookup(32'h1234_5A00, 8'h01, 0);
      phase = "R13 load with lookup";
      step();
      slot = m_ctr;
      do_load(32'h2000_0066, 32'h0000_1500 | V | USR, 4'h9, 1);
      do_ard(slot); do_drd(slot, 1);
      do_lookup(32'h2000_0000, 8'h66, 0);
    end

    phase = "R12 global invalidate";
    do_awr(3, 32'h0040_0000 | 32'h200 | V | 32'h11);
    do_lookup(32'h0040_0000, 8'h11, 0);
    step(); inval = 1;
    do_lookup(32'h0040_0000, 8'h11, 0);
    do_ard(3); do_ard(7); do_drd(5, 0); do_drd(3, 1);

    step(); step(); step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule